// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave end of a four-wire serial control link. An external microcontroller uses it to program a small bank of control registers and to read status registers back. The microcontroller drives a serial clock, a serial data input and an active-low select. The block returns a serial data output with a separate drive enable, so the line can be shared, and an active-low interrupt. The block runs from a fast system clock. It synchronises all three serial pins into that clock and finds the serial clock edges by comparing successive samples. It therefore works whichever way the serial clock rests between transfers.

Each transfer is one command byte followed by one data byte, most significant bit first. Bit 7 of the command byte selects a read (1) or a write (0), and bits 6:0 give the register address. A write is committed only when select is released after all 16 bits have arrived. On a read, the addressed register is shifted out during the second byte.

Status events from the surrounding logic each latch a byte and mark a pending flag. The pending flags form a fixed-priority queue that drives the interrupt pin. The interrupt pin can assert only while select is high, and it is cleared when select goes low. Reading a status register removes its entry from the queue.

Top module: `sctl_top`

## Requirements
- R1: A write transfer (command bit 7 = 0) to control address k, with k below NCTL, stores the data byte in control register k. `ctrl_q[8k+7:8k]` shows the new value only after `cs_n` returns high. A read transfer (command bit 7 = 1) changes no control register, whatever its data byte.
- R2: `sdi` is sampled on rising `sck` edges. `sdo` changes only on falling `sck` edges. During the second byte of a read, `sdo` presents the addressed register MSB first. The first bit becomes valid after the falling edge that follows the 8th rising edge. `sdo` stays 0 during the first byte.
- R3: Both clocking forms give the same results. In the idle-low form there are 16 pulses. In the idle-high form there are 17 falling edges, and `cs_n` is released while `sck` is low. Clock edges after the 16th captured bit change neither the captured bits nor the output.
- R4: A transfer that ends with fewer than 16 rising edges while `cs_n` is low is discarded, and no register changes.
- R5: `sdo_oe` is 0 whenever `cs_n` is high and 1 while `cs_n` is low.
- R6: The register map is as follows. Addresses 0..NCTL-1 are read/write control registers. Address STAT_BASE+k (default 8+k) reads status register k. Address ID_ADDR (default 16) returns bit 7 = any event pending, and the low bits give the index of the highest-priority pending event; index 0 has the highest priority. Reads of unmapped addresses return 0. Writes to anything other than a control register are ignored.
- R7: A one-cycle pulse on `evt[k]` loads `stat_in[8k+7:8k]` into status register k and marks event k pending. A complete read of status register k clears that pending mark.
- R8: `irq_n` goes low while `cs_n` is high and any event is pending. Driving `cs_n` low forces `irq_n` high for the rest of the transfer. If events are still pending when `cs_n` returns high, `irq_n` asserts again.
- R9: After reset, `irq_n` = 1, `sdo_oe` = 0, `sdo` = 0 and all control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the microcontroller |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low transfer select |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo`; the line is released when 0 |
| irq_n | output | 1 | Active-low interrupt request |
| evt | input | NEV | Per-event one-cycle strobes |
| stat_in | input | 8*NEV | Status bytes, one per event |
| ctrl_q | output | 8*NCTL | Control register contents |

## Verification
A bit counter that is off by one shows up within one transfer. Either the wrong control byte appears on `ctrl_q` a few system cycles after `cs_n` rises, or a read returns a byte shifted by one position. Short-frame and idle-high transfers are aimed at exactly this fault. A pending-flag or priority error appears in the identifier byte of the next read and in the level of `irq_n` a few cycles after select is released. The bench therefore samples `irq_n` both mid-transfer and after each release.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;
  localparam int BW    = 8;
  localparam int FRAME = 2 * BW;
  typedef logic [BW-1:0] byte_t;
endpackage

// File: rtl/sctl_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for asynchronous pins, reset to a chosen value.
module sctl_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RVAL   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RVAL;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= RVAL;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sctl_shift.sv
`timescale 1ns/1ps
// Serial engine: edge detection, bit counting, input and output shifting.
module sctl_shift
  import sctl_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          cs_n_s,
  input  byte_t         rd_data,
  output logic [AW-1:0] rd_addr,
  output byte_t         cmd,
  output byte_t         data,
  output logic          done,
  output logic          cs_act,
  output logic          cs_start,
  output logic          sdo
);
  localparam int CW = $clog2(FRAME + 1);

  logic              sck_d, cs_d;
  logic [CW-1:0]     cnt, cnt_n;
  logic [FRAME-1:0]  sr, sr_n;
  byte_t             osr, osr_n;
  logic              sck_r, sck_f, cs_end;

  assign cs_act   = ~cs_n_s;
  assign sck_r    = sck_s & ~sck_d;
  assign sck_f    = ~sck_s & sck_d;
  assign cs_start = cs_act & ~cs_d;
  assign cs_end   = ~cs_act & cs_d;

  always_comb begin
    cnt_n = cnt;
    sr_n  = sr;
    osr_n = osr;
    if (cs_start) begin
      cnt_n = '0;
      osr_n = '0;
    end else if (cs_act) begin
      if (sck_r && cnt < CW'(FRAME)) begin
        sr_n  = {sr[FRAME-2:0], sdi_s};
        cnt_n = cnt + 1'b1;
      end
      if (sck_f) begin
        if (cnt == CW'(BW))
          osr_n = sr[BW-1] ? rd_data : '0;
        else if (cnt > CW'(BW) && cnt < CW'(FRAME))
          osr_n = {osr[BW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
      osr   <= '0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_act;
      cnt   <= cnt_n;
      sr    <= sr_n;
      osr   <= osr_n;
    end
  end

  assign rd_addr = sr[AW-1:0];
  assign cmd     = sr[FRAME-1:BW];
  assign data    = sr[BW-1:0];
  assign done    = cs_end && (cnt == CW'(FRAME));
  assign sdo     = osr[BW-1];

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (cnt == '0));
  // R3
  extra_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sck_r && cnt == CW'(FRAME)) |=> $stable(sr));
  // R2
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osr) |-> $past(sck_f || cs_start));
endmodule

// File: rtl/sctl_regs.sv
`timescale 1ns/1ps
// Register bank, read multiplexer, event queue and interrupt gate.
module sctl_regs
  import sctl_pkg::*;
#(
  parameter int NCTL      = 4,
  parameter int NEV       = 4,
  parameter int STAT_BASE = 8,
  parameter int ID_ADDR   = 16,
  parameter int AW        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    evt,
  input  logic [NEV*BW-1:0] stat_in,
  input  logic              done,
  input  byte_t             cmd,
  input  byte_t             data,
  input  logic [AW-1:0]     rd_addr,
  input  logic              cs_act,
  input  logic              cs_start,
  output byte_t             rd_data,
  output logic [NCTL*BW-1:0] ctrl_q,
  output logic              irq_n
);
  localparam int IDW = (NEV > 1) ? $clog2(NEV) : 1;

  byte_t          ctrl_r [NCTL];
  byte_t          ctrl_n [NCTL];
  byte_t          stat_r [NEV];
  byte_t          stat_n [NEV];
  logic [NEV-1:0] pend_r, pend_n;
  logic           irq_r, irq_nx;
  logic [AW-1:0]  f_addr;
  logic           wr_fire, rd_fire;
  logic [IDW-1:0] top;
  byte_t          id_v;

  assign f_addr  = cmd[AW-1:0];
  assign wr_fire = done & ~cmd[BW-1];
  assign rd_fire = done &  cmd[BW-1];

  always_comb begin
    for (int k = 0; k < NCTL; k++) begin
      ctrl_n[k] = ctrl_r[k];
      if (wr_fire && f_addr == AW'(k)) ctrl_n[k] = data;
    end
    for (int k = 0; k < NEV; k++) begin
      stat_n[k] = stat_r[k];
      pend_n[k] = pend_r[k];
      if (rd_fire && f_addr == AW'(STAT_BASE + k)) pend_n[k] = 1'b0;
      if (evt[k]) begin
        stat_n[k] = stat_in[k*BW +: BW];
        pend_n[k] = 1'b1;
      end
    end
    if (cs_start)    irq_nx = 1'b0;
    else if (cs_act) irq_nx = irq_r;
    else             irq_nx = |pend_r;
  end

  always_comb begin
    top = '0;
    for (int k = NEV - 1; k >= 0; k--)
      if (pend_r[k]) top = IDW'(k);
    id_v = '0;
    id_v[BW-1]  = |pend_r;
    id_v[IDW-1:0] = top;
    rd_data = '0;
    for (int k = 0; k < NCTL; k++)
      if (rd_addr == AW'(k)) rd_data = ctrl_r[k];
    for (int k = 0; k < NEV; k++)
      if (rd_addr == AW'(STAT_BASE + k)) rd_data = stat_r[k];
    if (rd_addr == AW'(ID_ADDR)) rd_data = id_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCTL; k++) ctrl_r[k] <= '0;
      for (int k = 0; k < NEV; k++)  stat_r[k] <= '0;
      pend_r <= '0;
      irq_r  <= 1'b0;
    end else begin
      for (int k = 0; k < NCTL; k++) ctrl_r[k] <= ctrl_n[k];
      for (int k = 0; k < NEV; k++)  stat_r[k] <= stat_n[k];
      pend_r <= pend_n;
      irq_r  <= irq_nx;
    end
  end

  for (genvar g = 0; g < NCTL; g++) begin : g_out
    assign ctrl_q[g*BW +: BW] = ctrl_r[g];
  end
  assign irq_n = ~irq_r;

  // R1
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(done && !cmd[BW-1]));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_r) |-> $past(!cs_act));
  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> !irq_r);
  // R7
  deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_r) < $countones($past(pend_r))) |-> $past(done));
endmodule

// File: rtl/sctl_top.sv
`timescale 1ns/1ps
// Serial register control port: top level.
module sctl_top
  import sctl_pkg::*;
#(
  parameter int NCTL      = 4,
  parameter int NEV       = 4,
  parameter int STAT_BASE = 8,
  parameter int ID_ADDR   = 16,
  parameter int SYNC      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                sdi,
  input  logic                cs_n,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                irq_n,
  input  logic [NEV-1:0]      evt,
  input  logic [NEV*BW-1:0]   stat_in,
  output logic [NCTL*BW-1:0]  ctrl_q
);
  localparam int AW = BW - 1;

  logic [1:0]    rst_pipe;
  logic          rst_i;
  logic [2:0]    pins_s;
  logic [AW-1:0] rd_addr;
  byte_t         rd_data, cmd, data;
  logic          done, cs_act, cs_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  sctl_sync #(.W(3), .STAGES(SYNC), .RVAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i), .d({cs_n, sck, sdi}), .q(pins_s)
  );

  sctl_shift #(.AW(AW)) u_shift (
    .clk(clk), .rst_n(rst_i),
    .sck_s(pins_s[1]), .sdi_s(pins_s[0]), .cs_n_s(pins_s[2]),
    .rd_data(rd_data), .rd_addr(rd_addr), .cmd(cmd), .data(data),
    .done(done), .cs_act(cs_act), .cs_start(cs_start), .sdo(sdo)
  );

  sctl_regs #(.NCTL(NCTL), .NEV(NEV), .STAT_BASE(STAT_BASE),
              .ID_ADDR(ID_ADDR), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_i), .evt(evt), .stat_in(stat_in),
    .done(done), .cmd(cmd), .data(data), .rd_addr(rd_addr),
    .cs_act(cs_act), .cs_start(cs_start), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .irq_n(irq_n)
  );

  assign sdo_oe = ~cs_n;
endmodule

// File: tb/sim_sctl_top.sv
`timescale 1ns/1ps
module sim_sctl_top;
  localparam int HP = 40;

  logic        clk = 1'b0;
  logic        rst_n, sck, sdi, cs_n;
  logic        sdo, sdo_oe, irq_n;
  logic [3:0]  evt;
  logic [31:0] stat_in;
  logic [31:0] ctrl_q;
  int          n_chk = 0, n_err = 0;
  logic        oe_mid, irq_mid;
  logic [7:0]  rd;

  always #2.5 clk = ~clk;

  sctl_top u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n), .evt(evt),
    .stat_in(stat_in), .ctrl_q(ctrl_q)
  );

  // {idle_high, command byte, data byte, expected byte}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 8'h00, 8'hA5, 8'hA5},
    {1'b1, 8'h01, 8'h3C, 8'h3C},
    {1'b0, 8'h03, 8'hFF, 8'hFF},
    {1'b1, 8'h80, 8'h00, 8'hA5},
    {1'b0, 8'h81, 8'h00, 8'h3C},
    {1'b0, 8'h83, 8'h5A, 8'hFF},
    {1'b0, 8'h02, 8'h81, 8'h81},
    {1'b1, 8'h82, 8'h00, 8'h81},
    {1'b0, 8'h90, 8'h00, 8'h00},
    {1'b0, 8'h85, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic hi, input logic [7:0] a, input logic [7:0] d,
                      input int nb, output logic [7:0] r);
    logic [15:0] w;
    w = {a, d};
    r = '0;
    @(negedge clk);
    sck = hi; #HP;
    cs_n = 1'b0; #HP;
    for (int i = 0; i < 16; i++) begin
      if (i < nb) begin
        if (hi) sck = 1'b0;
        sdi = w[15-i];
        #HP;
        if (i == 4) begin oe_mid = sdo_oe; irq_mid = irq_n; end
        if (i >= 8) r[15-i] = sdo;
        sck = 1'b1;
        #HP;
        if (!hi) sck = 1'b0;
      end
    end
    if (hi) begin sck = 1'b0; #HP; end
    #HP;
    cs_n = 1'b1; #HP;
    if (hi) sck = 1'b1;
    #HP;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #500000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; sdi = 1'b0; cs_n = 1'b1;
    evt = '0; stat_in = 32'h44332211;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk("R9 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R9 sdo_oe", {31'd0, sdo_oe}, 32'd0);
    chk("R9 sdo", {31'd0, sdo}, 32'd0);
    chk("R9 ctrl", ctrl_q, 32'd0);

    // table walk: R1 writes, R2/R6 reads, R3 idle-high rows
    for (int v = 0; v < 10; v++) begin
      xfer(VEC[v][24], VEC[v][23:16], VEC[v][15:8], 16, rd);
      if (VEC[v][23])
        chk("R2 R3 R6 read byte", {24'd0, rd}, {24'd0, VEC[v][7:0]});
      else
        chk("R1 R3 write", {24'd0, ctrl_q[VEC[v][17:16]*8 +: 8]}, {24'd0, VEC[v][7:0]});
    end
    chk("R5 oe during transfer", {31'd0, oe_mid}, 32'd1);
    chk("R5 oe idle", {31'd0, sdo_oe}, 32'd0);
    chk("R1 read left ctrl3", {24'd0, ctrl_q[31:24]}, 32'h0000_00FF);

    // R4 short frame discarded
    xfer(1'b0, 8'h00, 8'h11, 12, rd);
    chk("R4 short frame", {24'd0, ctrl_q[7:0]}, 32'h0000_00A5);
    xfer(1'b1, 8'h01, 8'h22, 15, rd);
    chk("R4 short idle-high", {24'd0, ctrl_q[15:8]}, 32'h0000_003C);

    // R6 write to a status address is ignored
    xfer(1'b0, 8'h09, 8'h77, 16, rd);
    chk("R6 no-write ctrl", ctrl_q, 32'hFF81_3CA5);

    // R7/R8 events
    @(negedge clk); evt = 4'b0100;
    @(negedge clk); evt = 4'b0010;
    @(negedge clk); evt = 4'b0000;
    repeat (4) @(negedge clk);
    chk("R8 irq on pending", {31'd0, irq_n}, 32'd0);
    xfer(1'b0, 8'h90, 8'h00, 16, rd);
    chk("R6 priority id", {24'd0, rd}, 32'h0000_0081);
    chk("R8 irq cleared by cs", {31'd0, irq_mid}, 32'd1);
    chk("R8 irq reasserts", {31'd0, irq_n}, 32'd0);
    xfer(1'b1, 8'h89, 8'h00, 16, rd);
    chk("R6 R7 status1", {24'd0, rd}, 32'h0000_0022);
    chk("R8 irq still pending", {31'd0, irq_n}, 32'd0);
    xfer(1'b0, 8'h90, 8'h00, 16, rd);
    chk("R7 dequeue id", {24'd0, rd}, 32'h0000_0082);
    xfer(1'b0, 8'h8A, 8'h00, 16, rd);
    chk("R7 status2", {24'd0, rd}, 32'h0000_0033);
    chk("R8 irq released", {31'd0, irq_n}, 32'd1);
    xfer(1'b1, 8'h90, 8'h00, 16, rd);
    chk("R7 queue empty", {24'd0, rd}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule